// File: doc/BRIEF.md
# Pipelined Burst SRAM with Load/Advance Control

This block is a synthesizable, scaled-down synchronous SRAM that stores 36-bit words, each split into four 9-bit lanes (eight data bits and one parity bit). One control pin picks the access for each cycle. Driven low, it loads a new address and starts a read or a write. Driven high, it steps a burst counter, and the burst continues in linear or interleaved order within an aligned group of four words. The address width is a parameter, so the depth is a parameter too.

Reads are pipelined. The word at an address taken on one enabled edge appears on `rdata` after the second enabled edge that follows. Write data is taken on that same second edge, so reads and writes can alternate with no idle cycle. An active-low clock enable freezes every register in the block and stretches the current cycle. The data-out bus has its own valid flag. That flag is gated by output enable and is forced low when no read result is in the output stage.

Top module: `burst_sram`

## Requirements
- R1: While `rst_n` is low, `rdata_vld` is 0. Reset leaves no access in flight.
- R2: A read whose address is taken on enabled edge k drives the stored word onto `rdata` after enabled edge k+2.
- R3: A write whose address is taken on enabled edge k takes `wdata` on enabled edge k+2. Lane i is bits [9i+8:9i], and it is written only when `lane_wr_n[i]` was 0 on edge k. Lanes with a 1 keep their old value.
- R4: A load (`burst_adv`=0) starts an access only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 on that edge. Any other combination deselects the block: nothing is written and no read result is produced.
- R5: With `burst_adv`=1, an active burst moves to its next word and keeps the read/write direction chosen at the load. `wr_n` and `addr` are ignored on those edges. While the block is deselected, an advance does nothing.
- R6: With `order_ilv`=0, word n of a burst (n=0..3) is at the start address with its two low bits replaced by (start[1:0]+n) mod 4.
- R7: With `order_ilv`=1, word n of a burst is at the start address with its two low bits replaced by start[1:0] XOR n.
- R8: While `clken_n` is 1, no register changes and `rdata` holds its value. All other inputs, including `wdata`, are ignored.
- R9: `rdata_vld` is 1 only when the output stage holds a read result and `out_en_n` is 0. It is 0 during a write's data phase, while deselected, and on the first output cycle after leaving deselect.
- R10: A read issued on the cycle right after a write to the same address returns the newly merged word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clken_n | input | 1 | Clock enable, active low; high stalls everything |
| sel_a_n | input | 1 | Select term, active low |
| sel_b | input | 1 | Select term, active high |
| sel_c_n | input | 1 | Select term, active low |
| wr_n | input | 1 | Write request at a load, active low |
| burst_adv | input | 1 | 1 advances the burst, 0 loads a new address |
| lane_wr_n | input | 4 | Per-lane write select, active low |
| addr | input | ADDR_W | Word address |
| order_ilv | input | 1 | Static strap: 1 interleaved, 0 linear burst order |
| out_en_n | input | 1 | Output enable, active low |
| wdata | input | 36 | Write data, taken two enabled edges after its address |
| rdata | output | 36 | Read data |
| rdata_vld | output | 1 | Read data valid |

## Verification
A write's data phase, where the array is updated from `wdata`, can fall in the same cycle as the array-access stage of a newer read. The two can also collide when the clock enable is pulled high just as the write data is due. Both cases are provoked by alternating single writes and reads at one address with no gap, and by stalling in the middle of write and read bursts while `wdata` is driven with random values. They are judged by the word each later read returns, compared against a reference array that is updated only at the edge where the write's data is taken.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clken_n,
  input  logic                      sel_a_n,
  input  logic                      sel_b,
  input  logic                      sel_c_n,
  input  logic                      wr_n,
  input  logic                      burst_adv,
  input  logic [LANES-1:0]          lane_wr_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      order_ilv,
  input  logic                      out_en_n,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   rdata,
  output logic                      rdata_vld
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic              act, act_wr;
  logic [ADDR_W-1:0] base;
  logic [1:0]        cnt;
  logic              s1_v, s1_wr, s2_v, s2_wr, out_rd;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_bw, s2_bw;

  wire run  = ~clken_n;
  wire sel  = ~sel_a_n & sel_b & ~sel_c_n;
  wire [1:0] nxt_cnt = cnt + 2'd1;
  wire [1:0] off = order_ilv ? (base[1:0] ^ nxt_cnt) : (base[1:0] + nxt_cnt);
  wire [ADDR_W-1:0] adv_addr = {base[ADDR_W-1:2], off};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; act_wr <= 1'b0; base <= '0; cnt <= '0;
      s1_v <= 1'b0; s1_wr <= 1'b0; s1_addr <= '0; s1_bw <= '1;
      s2_v <= 1'b0; s2_wr <= 1'b0; s2_addr <= '0; s2_bw <= '1;
      out_rd <= 1'b0;
    end else if (run) begin
      if (!burst_adv) begin
        act     <= sel;
        act_wr  <= ~wr_n;
        base    <= addr;
        cnt     <= 2'd0;
        s1_v    <= sel;
        s1_wr   <= ~wr_n;
        s1_addr <= addr;
      end else begin
        cnt     <= nxt_cnt;
        s1_v    <= act;
        s1_wr   <= act_wr;
        s1_addr <= adv_addr;
      end
      s1_bw   <= lane_wr_n;
      s2_v    <= s1_v;
      s2_wr   <= s1_wr;
      s2_addr <= s1_addr;
      s2_bw   <= s1_bw;
      out_rd  <= s2_v & ~s2_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (run && s2_v && s2_wr)
      for (int i = 0; i < LANES; i++)
        if (!s2_bw[i]) mem[s2_addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       rdata <= '0;
    else if (run && s2_v && !s2_wr)   rdata <= mem[s2_addr];
  end

  assign rdata_vld = out_rd & ~out_en_n;
endmodule

module burst_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clken_n,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic              burst_adv,
  input logic              out_en_n,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_vld,
  input logic              act,
  input logic              s1_v,
  input logic              s2_v,
  input logic              s2_wr
);
  always_comb begin
    assert_reset_quiet_R1: assert (rst_n || !rdata_vld);
    assert_oe_gate_R9: assert (!(out_en_n && rdata_vld));
  end

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clken_n |=> $stable(rdata));

  assert_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clken_n && !burst_adv && (sel_a_n || !sel_b || sel_c_n)) |=> !s1_v);

  assert_idle_adv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clken_n && burst_adv && !act) |=> !s1_v);

  assert_write_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clken_n && s2_v && s2_wr) |=> !rdata_vld);

  assert_read_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clken_n && s2_v && !s2_wr) |=> (rdata_vld == !out_en_n));
endmodule

bind burst_sram burst_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clken_n(clken_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
  .sel_c_n(sel_c_n), .burst_adv(burst_adv), .out_en_n(out_en_n), .rdata(rdata),
  .rdata_vld(rdata_vld), .act(act), .s1_v(s1_v), .s2_v(s2_v), .s2_wr(s2_wr)
);

// File: tb/test_burst_sram.sv
module test_burst_sram;
  localparam int AW = 8;
  localparam int DW = 36;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, clken_n, sel_a_n, sel_b, sel_c_n, wr_n, burst_adv, order_ilv, out_en_n;
  logic [3:0]    lane_wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic          rdata_vld;

  burst_sram #(.ADDR_W(AW)) i_burst_sram (
    .clk(clk), .rst_n(rst_n), .clken_n(clken_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .wr_n(wr_n), .burst_adv(burst_adv), .lane_wr_n(lane_wr_n),
    .addr(addr), .order_ilv(order_ilv), .out_en_n(out_en_n), .wdata(wdata),
    .rdata(rdata), .rdata_vld(rdata_vld)
  );

  typedef struct packed {
    logic [1:0]    kind;
    logic [AW-1:0] a;
    logic [3:0]    bw;
    logic [DW-1:0] d;
  } slot_t;

  localparam logic [2:0] ON  = 3'b010;
  localparam logic [1:0] K_NONE = 2'd0, K_RD = 2'd1, K_WR = 2'd2;

  logic [DW-1:0] ref_mem [256];
  slot_t p1, p2;
  bit    exp_rd, fresh, stalled, running;
  logic [DW-1:0] expq[$];
  string tagq[$];
  string cur_tag;
  logic [DW-1:0] last_rd;
  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act_v, input logic [DW-1:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
    end
  endtask

  function automatic logic [DW-1:0] rnd();
    logic [63:0] t = {$urandom(), $urandom()};
    return t[DW-1:0];
  endfunction

  function automatic slot_t mk(input logic [1:0] k, input logic [AW-1:0] a, input logic [3:0] b, input logic [DW-1:0] d);
    slot_t s;
    s.kind = k; s.a = a; s.bw = b; s.d = d;
    return s;
  endfunction

  // Burst word n: linear (R6) adds n modulo 4, interleaved (R7) XORs n
  function automatic logic [AW-1:0] baddr(input logic [AW-1:0] s, input int n, input bit ilv);
    logic [1:0] nn = n[1:0];
    logic [1:0] o = ilv ? (s[1:0] ^ nn) : (s[1:0] + nn);
    return {s[AW-1:2], o};
  endfunction

  task automatic cyc(input bit c_n, input logic [2:0] ce, input bit w_n, input bit adv,
                     input logic [3:0] b, input logic [AW-1:0] a, input bit o_n, input slot_t s);
    clken_n = c_n; {sel_a_n, sel_b, sel_c_n} = ce; wr_n = w_n; burst_adv = adv;
    lane_wr_n = b; addr = a; out_en_n = o_n;
    wdata = (!c_n && p2.kind == K_WR) ? p2.d : rnd();
    @(posedge clk);
    stalled = c_n;
    if (!c_n) begin
      if (p2.kind == K_WR)
        for (int i = 0; i < 4; i++)
          if (!p2.bw[i]) ref_mem[p2.a][9*i +: 9] = p2.d[9*i +: 9];
      exp_rd = (p2.kind == K_RD);
      if (p2.kind == K_RD) begin
        expq.push_back(ref_mem[p2.a]);
        tagq.push_back(cur_tag);
      end
      fresh = (p2.kind == K_RD);
      p2 = p1;
      p1 = s;
    end
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 3'b110, 1, 0, 4'hF, AW'($urandom()), 0, mk(K_NONE, '0, '1, '0));
  endtask

  task automatic wr_burst(input logic [AW-1:0] a, input int len, input logic [3:0] b);
    for (int n = 0; n < len; n++)
      cyc(0, ON, 0, n != 0, b, (n == 0) ? a : AW'($urandom()), 0,
          mk(K_WR, baddr(a, n, order_ilv), b, rnd()));
  endtask

  // advance cycles drive wr_n low to show it is ignored (R5)
  task automatic rd_burst(input logic [AW-1:0] a, input int len, input bit o_n);
    for (int n = 0; n < len; n++)
      cyc(0, ON, n != 0 ? 1'b0 : 1'b1, n != 0, 4'($urandom()), (n == 0) ? a : AW'($urandom()), o_n,
          mk(K_RD, baddr(a, n, order_ilv), '1, '0));
  endtask

  always @(negedge clk) begin
    if (rst_n && running) begin
      chk(rdata_vld == (exp_rd && !out_en_n), "R9", DW'(rdata_vld), DW'(exp_rd && !out_en_n));
      if (fresh) begin
        logic [DW-1:0] e;
        string t;
        fresh = 0;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(rdata === e, t, rdata, e);
      end else if (stalled) begin
        chk(rdata === last_rd, "R8", rdata, last_rd);
      end
      last_rd = rdata;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    running = 0; exp_rd = 0; fresh = 0; stalled = 0; last_rd = '0;
    p1 = mk(K_NONE, '0, '1, '0); p2 = p1;
    rst_n = 0; clken_n = 1; {sel_a_n, sel_b, sel_c_n} = 3'b110; wr_n = 1; burst_adv = 0;
    lane_wr_n = '1; addr = '0; order_ilv = 0; out_en_n = 0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rdata_vld == 1'b0, "R1", DW'(rdata_vld), '0);   // R1 reset state
    rst_n = 1;
    running = 1;
    @(posedge clk); #1;
    idle(2);

    cur_tag = "R6";                                     // R6 linear bursts, wrap in group of 4
    order_ilv = 0;
    wr_burst(8'h10, 4, 4'h0);
    idle(3);
    rd_burst(8'h12, 4, 0);
    idle(3);

    cur_tag = "R2";                                     // R2 single read latency
    rd_burst(8'h11, 1, 0);
    idle(3);

    cur_tag = "R7";                                     // R7 interleaved bursts
    order_ilv = 1;
    wr_burst(8'h21, 4, 4'h0);
    idle(3);
    rd_burst(8'h22, 4, 0);
    rd_burst(8'h23, 3, 0);
    idle(3);

    cur_tag = "R3";                                     // R3 lane masks
    wr_burst(8'h12, 1, 4'b1010);
    wr_burst(8'h13, 1, 4'b0101);
    wr_burst(8'h10, 1, 4'b1111);
    idle(3);
    rd_burst(8'h12, 1, 0);
    rd_burst(8'h13, 1, 0);
    rd_burst(8'h10, 1, 0);
    idle(3);

    cur_tag = "R10";                                    // R10 write then read, no gap
    wr_burst(8'h30, 1, 4'h0);
    rd_burst(8'h30, 1, 0);
    wr_burst(8'h31, 1, 4'h0);
    rd_burst(8'h31, 1, 0);
    wr_burst(8'h30, 1, 4'b1100);
    rd_burst(8'h30, 1, 0);
    idle(3);

    cur_tag = "R8";                                     // R8 stalls inside bursts
    cyc(0, ON, 1, 0, '1, 8'h20, 0, mk(K_RD, 8'h20, '1, '0));
    cyc(1, ON, 0, 0, '0, 8'h33, 0, mk(K_NONE, '0, '1, '0));
    cyc(1, 3'b110, 0, 0, '0, 8'h40, 0, mk(K_NONE, '0, '1, '0));
    cyc(0, ON, 1, 1, '1, 8'h00, 0, mk(K_RD, 8'h21, '1, '0));
    cyc(0, ON, 1, 1, '1, 8'h00, 0, mk(K_RD, 8'h22, '1, '0));
    cyc(1, ON, 1, 1, '1, 8'h00, 0, mk(K_NONE, '0, '1, '0));
    cyc(1, ON, 1, 1, '1, 8'h00, 1, mk(K_NONE, '0, '1, '0));
    cyc(0, ON, 1, 1, '1, 8'h00, 0, mk(K_RD, 8'h23, '1, '0));
    idle(3);
    begin
      slot_t w0, w1;
      w0 = mk(K_WR, 8'h24, 4'h0, rnd());
      w1 = mk(K_WR, 8'h25, 4'h0, rnd());
      cyc(0, ON, 0, 0, 4'h0, 8'h24, 0, w0);
      cyc(0, ON, 0, 1, 4'h0, 8'h00, 0, w1);
      cyc(1, ON, 0, 0, 4'h0, 8'h26, 0, mk(K_NONE, '0, '1, '0));
      cyc(1, ON, 0, 0, 4'h0, 8'h27, 0, mk(K_NONE, '0, '1, '0));
      cyc(0, 3'b110, 1, 0, '1, 8'h00, 0, mk(K_NONE, '0, '1, '0));
      cyc(1, 3'b110, 1, 0, '1, 8'h00, 0, mk(K_NONE, '0, '1, '0));
      idle(3);
      rd_burst(8'h24, 2, 0);
      idle(3);
    end

    cur_tag = "R4";                                     // R4 each select term wrong
    cyc(0, 3'b110, 0, 0, 4'h0, 8'h10, 0, mk(K_NONE, '0, '1, '0));
    cyc(0, 3'b000, 0, 0, 4'h0, 8'h11, 0, mk(K_NONE, '0, '1, '0));
    cyc(0, 3'b011, 0, 0, 4'h0, 8'h12, 0, mk(K_NONE, '0, '1, '0));
    cyc(0, 3'b000, 1, 0, 4'h0, 8'h13, 0, mk(K_NONE, '0, '1, '0));
    idle(3);
    rd_burst(8'h10, 4, 0);
    idle(3);

    cur_tag = "R5";                                     // R5 advance while deselected
    cyc(0, ON, 0, 1, 4'h0, 8'h20, 0, mk(K_NONE, '0, '1, '0));
    cyc(0, ON, 1, 1, 4'h0, 8'h21, 0, mk(K_NONE, '0, '1, '0));
    cyc(0, 3'b000, 0, 1, 4'h0, 8'h22, 0, mk(K_NONE, '0, '1, '0));
    rd_burst(8'h20, 4, 0);
    idle(3);

    cur_tag = "R9";                                     // R9 output enable gating
    order_ilv = 0;
    rd_burst(8'h30, 1, 1);
    rd_burst(8'h31, 1, 0);
    rd_burst(8'h10, 4, 1);
    cyc(0, ON, 1, 0, '1, 8'h12, 0, mk(K_RD, 8'h12, '1, '0));
    cyc(0, ON, 1, 0, '1, 8'h13, 1, mk(K_RD, 8'h13, '1, '0));
    cyc(0, 3'b110, 1, 0, '1, 8'h00, 0, mk(K_NONE, '0, '1, '0));
    cyc(0, 3'b110, 1, 0, '1, 8'h00, 0, mk(K_NONE, '0, '1, '0));
    idle(3);

    summary();
  end
endmodule